// File: doc/BRIEF.md
# Zone Access Bitmap Tracker

This block keeps a record of which cache lines inside fixed-size memory zones have already been requested. A zone is 256 consecutive 64-byte lines. Each tracked zone owns one table entry. The entry holds a bitmap with one bit per line and two saturating counters: one counts first touches of lines in the zone, the other counts repeat touches. A replacement-policy engine can feed it every memory request and use the answer to judge how likely an incoming line is to be used again.

The table is set-associative: 16 sets of 12 ways, 192 zone entries in all. Each request carries a byte address. The block looks up the zone in its set. If the zone is absent, it claims the least recently used way of that set. One cycle after the request, the block reports three values, all as they stood before the request changed anything:
- whether the addressed line had been touched earlier (a map hit);
- the zone's repeat count;
- the zone's first-touch count.

Top module: `zone_access_tracker`

## Requirements
- R1: Address fields, from bit 0 upward: bits [5:0] are a byte offset that is ignored; bits [13:6] pick one of 256 lines in the zone; bits [17:14] pick one of 16 sets; bits [47:18] are the zone tag.
- R2: A request whose zone is absent from its set allocates an entry. Its response is map hit 0, repeat count 0, first-touch count 0. The new entry starts with only the addressed line marked and a first-touch count of 1.
- R3: A request to a line already marked in a resident zone reports map hit 1. It then raises that zone's repeat count by one.
- R4: A request to an unmarked line of a resident zone reports map hit 0. It raises the zone's first-touch count by one and marks the line.
- R5: Both counters are 8 bits wide and stop at 255 instead of wrapping.
- R6: The response is registered. It appears on the clock edge after the request with the response-valid flag set. It shows the entry state before that request's update.
- R7: Each set has 12 ways with strict LRU order. Every lookup, hit or allocation, makes the touched way the most recent. An allocation replaces the least recent way of the set.
- R8: Sets are independent. A zone with the same tag but a different set field occupies its own entry.
- R9: Synchronous reset empties the whole table and clears the response-valid flag.
- R10: A cycle without the request strobe changes no entry and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 48 | Request byte address |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_map_hit | output | 1 | Addressed line had been touched before |
| rsp_reuse_cnt | output | 8 | Zone repeat-touch count before the update |
| rsp_access_cnt | output | 8 | Zone first-touch count before the update |

## Verification
The bench fills one set with twelve zones and then refreshes the oldest one before forcing an allocation. A design that evicted by fill order instead of recency would then lose the refreshed zone instead of the second-oldest. It drives both counters past 255. A wrapping counter would report small values where 255 is expected.

The bench also checks that the second touch of a fresh zone reports a first-touch count of 1. This catches an allocation that fails to count or mark the triggering line. It checks that the counts seen are the values from before the update, since an off-by-one read would show the incremented value. Finally, it looks for state changes on idle cycles and leftover entries after reset.

// File: rtl/zat_pkg.sv
package zat_pkg;
  localparam int ZAT_ADDR_W     = 48;
  localparam int ZAT_BYTE_OFF_W = 6;
  localparam int ZAT_LINE_W     = 8;
  localparam int ZAT_SET_W      = 4;
  localparam int ZAT_WAYS       = 12;
  localparam int ZAT_CNT_W      = 8;

  typedef enum logic {
    LINE_FRESH   = 1'b0,
    LINE_TOUCHED = 1'b1
  } line_state_e;
endpackage

// File: rtl/zat_tag_match.sv
module zat_tag_match #(
  parameter int WAYS  = 12,
  parameter int TAG_W = 30,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [TAG_W-1:0] way_tag [WAYS],
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way
);
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_vld[w] && (way_tag[w] == probe_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/zat_lru_order.sv
module zat_lru_order #(
  parameter int WAYS = 12,
  localparam int WAY_W = $clog2(WAYS),
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  // age 0 = most recent, WAYS-1 = least recent
  logic [POS_W-1:0] age_q [WAYS];
  logic [POS_W-1:0] touched_age;

  assign touched_age = age_q[touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= POS_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) age_q[w] <= '0;
        else if (age_q[w] < touched_age) age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[w] == POS_W'(WAYS - 1)) victim_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/zone_access_tracker.sv
module zone_access_tracker
  import zat_pkg::*;
#(
  parameter int ADDR_W     = ZAT_ADDR_W,
  parameter int BYTE_OFF_W = ZAT_BYTE_OFF_W,
  parameter int LINE_W     = ZAT_LINE_W,
  parameter int SET_W      = ZAT_SET_W,
  parameter int WAYS       = ZAT_WAYS,
  parameter int CNT_W      = ZAT_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_map_hit,
  output logic [CNT_W-1:0]  rsp_reuse_cnt,
  output logic [CNT_W-1:0]  rsp_access_cnt
);
  localparam int LINES   = 1 << LINE_W;
  localparam int SETS    = 1 << SET_W;
  localparam int ENTRIES = SETS * WAYS;
  localparam int TAG_W   = ADDR_W - BYTE_OFF_W - LINE_W - SET_W;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ENT_W   = $clog2(ENTRIES);
  localparam int LINE_LSB = BYTE_OFF_W;
  localparam int SET_LSB  = BYTE_OFF_W + LINE_W;
  localparam int TAG_LSB  = SET_LSB + SET_W;

  // storage, written without reset so it can map onto RAM
  logic [TAG_W-1:0] tag_mem   [ENTRIES];
  logic [LINES-1:0] map_mem   [ENTRIES];
  logic [CNT_W-1:0] reuse_mem [ENTRIES];
  logic [CNT_W-1:0] acc_mem   [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [LINE_W-1:0] line_idx;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  zone_tag;
  logic [BYTE_OFF_W-1:0] unused_byte_off;

  assign line_idx        = req_addr[LINE_LSB +: LINE_W];
  assign set_idx         = req_addr[SET_LSB +: SET_W];
  assign zone_tag        = req_addr[TAG_LSB +: TAG_W];
  assign unused_byte_off = req_addr[BYTE_OFF_W-1:0];

  logic [TAG_W-1:0] set_tags [WAYS];
  logic [WAYS-1:0]  set_vld;
  logic             zone_hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] set_victim [SETS];
  logic [WAY_W-1:0] sel_way;
  logic [ENT_W-1:0] ent;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tags[w] = tag_mem[ENT_W'(int'(set_idx) * WAYS + w)];
      set_vld[w]  = vld_q[ENT_W'(int'(set_idx) * WAYS + w)];
    end
  end

  zat_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
    .way_vld   (set_vld),
    .way_tag   (set_tags),
    .probe_tag (zone_tag),
    .hit       (zone_hit),
    .hit_way   (hit_way)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_set_lru
    zat_lru_order #(.WAYS(WAYS)) lru_i (
      .clk        (clk),
      .rst        (rst),
      .touch      (req_valid && (set_idx == SET_W'(s))),
      .touch_way  (sel_way),
      .victim_way (set_victim[s])
    );
  end

  assign sel_way = zone_hit ? hit_way : set_victim[set_idx];
  assign ent     = ENT_W'(int'(set_idx) * WAYS + int'(sel_way));

  logic [LINES-1:0] cur_map;
  logic [CNT_W-1:0] cur_reuse, cur_acc;
  logic             line_seen;

  assign cur_map   = map_mem[ent];
  assign cur_reuse = reuse_mem[ent];
  assign cur_acc   = acc_mem[ent];
  assign line_seen = zone_hit && (cur_map[line_idx] == LINE_TOUCHED);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (req_valid) begin
      if (!zone_hit) begin
        tag_mem[ent]   <= zone_tag;
        map_mem[ent]   <= LINES'(1) << line_idx;
        reuse_mem[ent] <= '0;
        acc_mem[ent]   <= CNT_W'(1);
      end else if (line_seen) begin
        reuse_mem[ent] <= sat_inc(cur_reuse);
      end else begin
        acc_mem[ent]           <= sat_inc(cur_acc);
        map_mem[ent][line_idx] <= LINE_TOUCHED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q          <= '0;
      rsp_valid      <= 1'b0;
      rsp_map_hit    <= 1'b0;
      rsp_reuse_cnt  <= '0;
      rsp_access_cnt <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        vld_q[ent]     <= 1'b1;
        rsp_map_hit    <= line_seen;
        rsp_reuse_cnt  <= zone_hit ? cur_reuse : '0;
        rsp_access_cnt <= zone_hit ? cur_acc : '0;
      end
    end
  end
endmodule

// File: rtl/zat_checker.sv
module zat_checker #(
  parameter int ADDR_W     = 48,
  parameter int BYTE_OFF_W = 6,
  parameter int CNT_W      = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_map_hit,
  input logic [CNT_W-1:0]  rsp_reuse_cnt,
  input logic [CNT_W-1:0]  rsp_access_cnt
);
  localparam int LA_W = ADDR_W - BYTE_OFF_W;

  logic [BYTE_OFF_W-1:0] unused_low;
  assign unused_low = req_addr[BYTE_OFF_W-1:0];

  logic            last_v;
  logic [LA_W-1:0] last_line;
  logic            pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_v    <= 1'b0;
      last_line <= '0;
      pair_q    <= 1'b0;
    end else begin
      last_v    <= req_valid;
      last_line <= req_addr[ADDR_W-1:BYTE_OFF_W];
      pair_q    <= req_valid && last_v && (req_addr[ADDR_W-1:BYTE_OFF_W] == last_line);
    end
  end

  // R6: a response follows every request, and only a request
  assert_rsp_after_req_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_rsp_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R2: an entry reporting no first touches is fresh, so no repeats either
  assert_fresh_entry_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_access_cnt == '0) |-> (rsp_reuse_cnt == '0 && !rsp_map_hit));

  // R3: a marked line implies the zone saw at least one first touch
  assert_hit_has_access_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_map_hit) |-> (rsp_access_cnt != '0));

  // R3: back-to-back touches of one line: the second one is a map hit
  assert_repeat_is_hit_R3: assert property (@(posedge clk) disable iff (rst)
    pair_q |-> rsp_map_hit);

  // R5: repeat count steps by one on a hit and stops at its maximum
  assert_reuse_saturates_R5: assert property (@(posedge clk) disable iff (rst)
    pair_q |-> (rsp_reuse_cnt == ($past(rsp_map_hit)
                 ? (($past(rsp_reuse_cnt) == '1) ? '1 : $past(rsp_reuse_cnt) + 1'b1)
                 : $past(rsp_reuse_cnt))));
endmodule

bind zone_access_tracker zat_checker #(
  .ADDR_W(ADDR_W), .BYTE_OFF_W(BYTE_OFF_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_map_hit(rsp_map_hit),
  .rsp_reuse_cnt(rsp_reuse_cnt), .rsp_access_cnt(rsp_access_cnt)
);

// File: tb/zone_access_tracker_tb_top.sv
module zone_access_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [47:0] req_addr = '0;
  logic        rsp_valid, rsp_map_hit;
  logic [7:0]  rsp_reuse_cnt, rsp_access_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zone_access_tracker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_map_hit(rsp_map_hit),
    .rsp_reuse_cnt(rsp_reuse_cnt), .rsp_access_cnt(rsp_access_cnt)
  );

  function automatic logic [47:0] mk(input int tag, input int set, input int line, input int off);
    return {30'(tag), 4'(set), 8'(line), 6'(off)};
  endfunction

  task automatic expect_rsp(input string req, input logic h, input int ru, input int ac);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_map_hit !== h || rsp_reuse_cnt !== 8'(ru) || rsp_access_cnt !== 8'(ac)) begin
      errors++;
      $display("FAIL %s: got valid=%0b hit=%0b reuse=%0d acc=%0d, expected valid=1 hit=%0b reuse=%0d acc=%0d",
               req, rsp_valid, rsp_map_hit, rsp_reuse_cnt, rsp_access_cnt, h, ru, ac);
    end
  endtask

  task automatic touch(input logic [47:0] a, input string req, input logic h, input int ru, input int ac);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(req, h, ru, ac);
  endtask

  task automatic touch_quiet(input logic [47:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic burst(input logic [47:0] a, input int n, input string req, input logic h, input int ru, input int ac);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    repeat (n) @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(req, h, ru, ac);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: rsp_valid=%0b during reset, expected 0", rsp_valid);
    end
    rst = 1'b0;
  endtask

  task automatic t_basic();
    touch(mk(100, 3, 0, 0),    "R2 allocate",          1'b0, 0, 0);
    touch(mk(100, 3, 0, 0),    "R2 fresh line marked", 1'b1, 0, 1);
    touch(mk(100, 3, 0, 6'h3f),"R1 offset ignored",    1'b1, 1, 1);
    touch(mk(100, 3, 1, 0),    "R4 new line",          1'b0, 2, 1);
    touch(mk(100, 3, 1, 0),    "R4 line now marked",   1'b1, 2, 2);
  endtask

  task automatic t_sets();
    touch(mk(100, 4, 0, 0), "R8 other set fresh", 1'b0, 0, 0);
    touch(mk(100, 3, 0, 0), "R8 first set kept",  1'b1, 3, 2);
  endtask

  task automatic t_lru();
    for (int t = 101; t <= 111; t++) touch_quiet(mk(t, 3, 0, 0));
    touch(mk(111, 3, 0, 0), "R7 last fill resident", 1'b1, 0, 1);
    touch(mk(100, 3, 0, 0), "R7 refresh oldest",     1'b1, 4, 2);
    touch(mk(112, 3, 0, 0), "R7 allocate new",       1'b0, 0, 0);
    touch(mk(100, 3, 0, 0), "R7 refreshed survives", 1'b1, 5, 2);
    touch(mk(101, 3, 0, 0), "R7 least recent gone",  1'b0, 0, 0);
    touch(mk(103, 3, 0, 0), "R7 younger way kept",   1'b1, 0, 1);
  endtask

  task automatic t_idle();
    touch(mk(200, 5, 9, 0), "R10 setup", 1'b0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      req_addr = mk(200, 5, 9, i);
      checks++;
      if (rsp_valid !== 1'b0) begin
        errors++;
        $display("FAIL R10: rsp_valid=%0b while idle, expected 0", rsp_valid);
      end
    end
    touch(mk(200, 5, 9, 0), "R10 no idle update", 1'b1, 0, 1);
  endtask

  task automatic t_saturate();
    touch(mk(300, 7, 0, 0), "R5 zone alloc", 1'b0, 0, 0);
    for (int l = 1; l < 256; l++) touch_quiet(mk(300, 7, l, 0));
    touch(mk(300, 7, 0, 0), "R5 access stops at 255", 1'b1, 0, 255);
    burst(mk(300, 7, 0, 0), 254, "R5 reuse below max", 1'b1, 254, 255);
    burst(mk(300, 7, 0, 0), 10,  "R5 reuse stops at 255", 1'b1, 255, 255);
  endtask

  task automatic t_reset_clears();
    do_reset();
    touch(mk(100, 3, 0, 0), "R9 table emptied", 1'b0, 0, 0);
    touch(mk(300, 7, 0, 0), "R9 second zone emptied", 1'b0, 0, 0);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: rsp_valid=%0b after reset, expected 0", rsp_valid);
    end
    t_basic();
    t_sets();
    t_lru();
    t_idle();
    t_saturate();
    t_reset_clears();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run still going, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule